// File: doc/BRIEF.md
# RTC Periodic Interrupt and Square-Wave Generator

This block is the periodic-event slice of a real-time-clock register file. A system clock runs the logic, and a one-cycle enable strobe marks each edge of a 32.768 kHz time base. A 4-bit rate code in control register A sets the event period. Two enables in control register B choose the consumers of that event. One enable is for a periodic interrupt, which latches flags in status register C and raises an interrupt line. The other is for a square-wave output with a 50% duty cycle.

A host uses a byte-wide port with a 2-bit address to reach the three registers. Address 0 selects A, 1 selects B and 2 selects C. Reading register C returns its value and clears it, which also acknowledges the interrupt. Writing register A or register B restarts the divider, so a new rate or a new enable takes effect from a clean phase.

Top module: `rtc_pulse_unit`

## Requirements
- R1: After reset, register A reads 0x26, register B reads 0x02 and register C reads 0x00. Both `irqOut` and `sqwOut` are low.
- R2: A write with address 0 stores all 8 bits into register A, and address 1 stores into register B. A read returns the addressed register on `rdData` in the same cycle as `rdEn`.
- R3: Writes to address 2 (register C) and address 3 are ignored. Address 3 reads as 0x00.
- R4: When the rate code (register A bits 3:0) is 0, the divider is stopped. No flag is set in C, `irqOut` stays low and `sqwOut` stays low, whatever the enables are.
- R5: With the interrupt enable set (register B bit 6, mask 0x40), the first periodic event after a restart occurs 2^(n-1) ticks later, for an effective code n from 3 to 15. That event sets register C bits 7 and 6 (0xC0) and raises `irqOut` in the cycle after the tick.
- R6: Rate codes 1 and 2 behave as codes 8 and 9, which gives periods of 128 and 256 ticks.
- R7: With the square-wave enable set (register B bit 3, mask 0x08), `sqwOut` is low for the first half-period of 2^(n-2) ticks after a restart. It is then high for one half-period and low again for the next, and so on. While bit 3 is clear, `sqwOut` is low.
- R8: The two paths are gated independently. With only the square-wave enable set, the square wave runs, register C stays 0x00 and `irqOut` stays low. With only the interrupt enable set, `sqwOut` stays low.
- R9: A read of register C returns its current value in the read cycle and then clears it. `irqOut` is low from the next cycle onward.
- R10: Any write to register A or register B restarts the divider, and the next event comes a full period after the write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tickEn | input | 1 | One-cycle strobe per time-base edge |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (clears C when address is 2) |
| addr | input | 2 | Register select: 0 = A, 1 = B, 2 = C |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data for the addressed register |
| irqOut | output | 1 | Periodic interrupt, high while C bit 7 is set |
| sqwOut | output | 1 | Square-wave output |

## Verification
A wrong divider count shows up as an `irqOut` rise one or more ticks away from 2^(n-1), at the first event after a restart. It also shows as a `sqwOut` edge off the half-period boundary within the first half-period. A missing restart leaves a leftover count, so the next event after a write comes early. A wrong gating term lets flags appear in register C, or a square wave appear, under an enable that should block it; such a fault is visible within one period. A wrong alias of codes 1 and 2 gives a period far from 128 or 256 ticks, which counting ticks to the first interrupt exposes.

// File: rtl/rtc_pulse_pkg.sv
package rtc_pulse_pkg;
  localparam int RATE_W = 4;
  localparam int DATA_W = 8;
  // widest half period is 2^(2^RATE_W - 3) ticks
  localparam int CNT_W = (1 << RATE_W) - 3;
  localparam int PIE_BIT = 6;
  localparam int SQW_BIT = 3;
  localparam logic [DATA_W-1:0] RESET_A = 8'h26;
  localparam logic [DATA_W-1:0] RESET_B = 8'h02;
  localparam logic [DATA_W-1:0] EVT_FLAGS = 8'hC0;

  typedef struct packed {
    logic restart;
    logic run;
    logic [RATE_W-1:0] rate;
  } ctrlStrobes_t;
endpackage

// File: rtl/rtc_pulse_dp.sv
module rtc_pulse_dp
  import rtc_pulse_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tickEn,
  input  ctrlStrobes_t strb,
  output logic phase,
  output logic periodEvt
);
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] halfLast;
  logic atHalf;

  always_comb begin
    halfLast = (CNT_W'(1) << (strb.rate - RATE_W'(2))) - CNT_W'(1);
    atHalf = (cnt == halfLast);
    periodEvt = tickEn & strb.run & ~strb.restart & atHalf & phase;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      phase <= 1'b0;
    end else if (strb.restart || !strb.run) begin
      cnt <= '0;
      phase <= 1'b0;
    end else if (tickEn) begin
      if (atHalf) begin
        cnt <= '0;
        phase <= ~phase;
      end else begin
        cnt <= cnt + CNT_W'(1);
      end
    end
  end
endmodule

// File: rtl/rtc_pulse_ctrl.sv
module rtc_pulse_ctrl
  import rtc_pulse_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic wrEn,
  input  logic rdEn,
  input  logic [1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic periodEvt,
  input  logic phase,
  output ctrlStrobes_t strb,
  output logic [DATA_W-1:0] rdData,
  output logic [DATA_W-1:0] regA,
  output logic [DATA_W-1:0] regB,
  output logic [DATA_W-1:0] regC,
  output logic irqOut,
  output logic sqwOut
);
  logic [RATE_W-1:0] rawRate;
  logic [RATE_W-1:0] effRate;

  always_comb begin
    rawRate = regA[RATE_W-1:0];
    if (rawRate == RATE_W'(1) || rawRate == RATE_W'(2))
      effRate = rawRate + RATE_W'(7);
    else
      effRate = rawRate;
    strb.rate = effRate;
    strb.run = (effRate != '0) && (regB[PIE_BIT] || regB[SQW_BIT]);
    strb.restart = wrEn && (addr == 2'd0 || addr == 2'd1);
  end

  always_comb begin
    case (addr)
      2'd0: rdData = regA;
      2'd1: rdData = regB;
      2'd2: rdData = regC;
      default: rdData = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regA <= RESET_A;
      regB <= RESET_B;
    end else if (wrEn) begin
      if (addr == 2'd0) regA <= wrData;
      else if (addr == 2'd1) regB <= wrData;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regC <= '0;
    end else begin
      if (periodEvt && regB[PIE_BIT])
        regC <= EVT_FLAGS;
      else if (rdEn && addr == 2'd2)
        regC <= '0;
    end
  end

  assign irqOut = regC[DATA_W-1];
  assign sqwOut = phase & regB[SQW_BIT];
endmodule

// File: rtl/rtc_pulse_unit.sv
module rtc_pulse_unit
  import rtc_pulse_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic tickEn,
  input  logic wrEn,
  input  logic rdEn,
  input  logic [1:0] addr,
  input  logic [7:0] wrData,
  output logic [7:0] rdData,
  output logic irqOut,
  output logic sqwOut
);
  ctrlStrobes_t strb;
  logic phase;
  logic periodEvt;
  logic [DATA_W-1:0] regA;
  logic [DATA_W-1:0] regB;
  logic [DATA_W-1:0] regC;

  rtc_pulse_ctrl ctrl (
    .clk(clk), .rst_n(rst_n), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .periodEvt(periodEvt), .phase(phase), .strb(strb),
    .rdData(rdData), .regA(regA), .regB(regB), .regC(regC),
    .irqOut(irqOut), .sqwOut(sqwOut)
  );

  rtc_pulse_dp dp (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .strb(strb),
    .phase(phase), .periodEvt(periodEvt)
  );
endmodule

// File: rtl/rtc_pulse_chk.sv
module rtc_pulse_chk (
  input logic clk,
  input logic rst_n,
  input logic tickEn,
  input logic wrEn,
  input logic rdEn,
  input logic [1:0] addr,
  input logic [7:0] wrData,
  input logic irqOut,
  input logic sqwOut,
  input logic [7:0] regB,
  input logic [7:0] regC
);
  assert_irq_on_tick_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irqOut) |-> ($past(tickEn) && $past(regB[6])));

  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (rdEn && addr == 2'd2 && !tickEn) |=> !irqOut);

  assert_c_write_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && addr == 2'd2 && !rdEn && !tickEn) |=> (regC == $past(regC)));

  assert_sqw_gate_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && addr == 2'd1 && !wrData[3]) |=> !sqwOut);

  assert_rate_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrEn && addr == 2'd0 && wrData[3:0] == 4'd0) |=> !sqwOut);

  assert_sqw_steps_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sqwOut) |-> ($past(tickEn) || $past(wrEn)));
endmodule

bind rtc_pulse_unit rtc_pulse_chk chk (
  .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .wrEn(wrEn), .rdEn(rdEn),
  .addr(addr), .wrData(wrData), .irqOut(irqOut), .sqwOut(sqwOut),
  .regB(regB), .regC(regC)
);

// File: tb/rtc_pulse_unit_test.sv
module rtc_pulse_unit_test;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tickEn = 1'b0;
  logic wrEn = 1'b0;
  logic rdEn = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic irqOut;
  logic sqwOut;
  int errors = 0;
  int checks = 0;
  logic done = 1'b0;

  always #10 clk = ~clk;

  rtc_pulse_unit uut (
    .clk(clk), .rst_n(rst_n), .tickEn(tickEn), .wrEn(wrEn), .rdEn(rdEn),
    .addr(addr), .wrData(wrData), .rdData(rdData), .irqOut(irqOut),
    .sqwOut(sqwOut)
  );

  task automatic check(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk);
    rdEn = 1'b1; addr = a;
    #1 d = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk);
    tickEn = 1'b1;
    @(negedge clk);
    tickEn = 1'b0;
  endtask

  task automatic ticksToIrq(input int limit, output int n);
    n = 0;
    while (!irqOut && n < limit) begin
      tick();
      n++;
    end
  endtask

  task automatic testReset();
    logic [7:0] d;
    rd(2'd0, d); check(d == 8'h26, "R1 regA reset", d, 8'h26);
    rd(2'd1, d); check(d == 8'h02, "R1 regB reset", d, 8'h02);
    rd(2'd2, d); check(d == 8'h00, "R1 regC reset", d, 8'h00);
    check(!irqOut && !sqwOut, "R1 outputs low", {irqOut, sqwOut}, 0);
  endtask

  task automatic testPort();
    logic [7:0] d;
    wr(2'd0, 8'h5A); rd(2'd0, d); check(d == 8'h5A, "R2 regA write", d, 8'h5A);
    wr(2'd1, 8'h81); rd(2'd1, d); check(d == 8'h81, "R2 regB write", d, 8'h81);
    wr(2'd2, 8'hFF); rd(2'd2, d); check(d == 8'h00, "R3 regC write ignored", d, 0);
    check(!irqOut, "R3 irq after C write", irqOut, 0);
    wr(2'd3, 8'hFF); rd(2'd3, d); check(d == 8'h00, "R3 addr3 reads 0", d, 0);
    rd(2'd0, d); check(d == 8'h5A, "R3 addr3 write no effect on A", d, 8'h5A);
  endtask

  task automatic testRateZero();
    logic [7:0] d;
    int sawSqw = 0;
    wr(2'd0, 8'h20); wr(2'd1, 8'h48);
    for (int i = 0; i < 300; i++) begin
      tick();
      if (sqwOut || irqOut) sawSqw++;
    end
    check(sawSqw == 0, "R4 rate zero idle", sawSqw, 0);
    rd(2'd2, d); check(d == 8'h00, "R4 no flags", d, 0);
  endtask

  task automatic testPeriod(input logic [3:0] code, input int expTicks, input string tag);
    logic [7:0] d;
    int n;
    wr(2'd1, 8'h40);
    rd(2'd2, d);
    wr(2'd0, {4'h2, code});
    ticksToIrq(expTicks + 4, n);
    check(n == expTicks, tag, n, expTicks);
    rd(2'd2, d);
    check(d == 8'hC0, {tag, " flags"}, d, 8'hC0);
    @(negedge clk);
    check(!irqOut, "R9 irq cleared after read", irqOut, 0);
    rd(2'd2, d);
    check(d == 8'h00, "R9 regC cleared", d, 0);
  endtask

  task automatic testSqw();
    logic [7:0] d;
    logic exp;
    int bad = 0;
    int irqSeen = 0;
    wr(2'd0, 8'h23); wr(2'd1, 8'h08);
    check(!sqwOut, "R7 sqw low after restart", sqwOut, 0);
    for (int i = 1; i <= 12; i++) begin
      tick();
      exp = ((i / 2) % 2) == 1;
      if (sqwOut !== exp) begin
        bad++;
        $display("FAIL R7 tick %0d actual=%0b expected=%0b", i, sqwOut, exp);
      end
      if (irqOut) irqSeen++;
    end
    check(bad == 0, "R7 square wave shape", bad, 0);
    check(irqSeen == 0, "R8 irq low with only sqw", irqSeen, 0);
    rd(2'd2, d); check(d == 8'h00, "R8 no flags with only sqw", d, 0);
    wr(2'd1, 8'h40);
    bad = 0;
    for (int i = 0; i < 12; i++) begin
      tick();
      if (sqwOut) bad++;
    end
    check(bad == 0, "R8 sqw low with only irq", bad, 0);
    rd(2'd2, d);
  endtask

  task automatic testRestart();
    logic [7:0] d;
    int n;
    wr(2'd1, 8'h40);
    wr(2'd0, 8'h24);
    rd(2'd2, d);
    repeat (5) tick();
    wr(2'd0, 8'h24);
    ticksToIrq(20, n);
    check(n == 8, "R10 restart on A write", n, 8);
    rd(2'd2, d);
    repeat (6) tick();
    wr(2'd1, 8'h40);
    ticksToIrq(20, n);
    check(n == 8, "R10 restart on B write", n, 8);
    rd(2'd2, d);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    testReset();
    testPort();
    testRateZero();
    testPeriod(4'd3, 4, "R5 code3 period");
    testPeriod(4'd6, 32, "R5 code6 period");
    testPeriod(4'd15, 16384, "R5 code15 period");
    testPeriod(4'd1, 128, "R6 code1 alias");
    testPeriod(4'd2, 256, "R6 code2 alias");
    testSqw();
    testRestart();
    done = 1'b1;
  end

  initial begin
    fork
      begin
        wait (done);
      end
      begin
        repeat (150000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
      end
    join_any
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule